// File: doc/BRIEF.md
# Branch Target Buffer with Misfetch Hysteresis

This block is a small two-way set-associative store that maps branch addresses to predicted target addresses for an instruction fetch unit. Each fetch PC is looked up in the same cycle that a separate direction predictor produces its taken bit. When the address hits in the buffer and the direction predictor says taken, the block steers fetch to the stored target. In every other case fetch continues at the sequential address. On a miss the block also reports a fallback direction from the sign of the branch displacement. A branch that jumps backward is reported taken and a forward branch is reported not taken.

The back end drives an update port with each resolved branch. An entry is created only when a branch resolves taken and the buffer has no entry for it. A resolved not-taken branch never takes a slot. Indirect jumps can produce a different target on each execution. To keep such a jump from thrashing its entry, each entry counts misfetches, meaning hits predicted taken whose stored target proves wrong. The target is rewritten only when two misfetches arrive with no correct target between them. Inside a set, one least-recently-used bit per set picks the victim.

Top module: `tgt_buffer`

## Requirements
- R1: After reset no entry is valid, so every lookup reports `lk_hit` = 0 until an update creates an entry.
- R2: When a lookup hits and `lk_dir_taken` = 1, `lk_taken` = 1 and `lk_next_pc` is the stored target.
- R3: When a lookup hits and `lk_dir_taken` = 0, `lk_taken` = 0 and `lk_next_pc` = `lk_pc` + 4.
- R4: On a miss, `lk_next_pc` = `lk_pc` + 4 whatever `lk_dir_taken` is, and `lk_taken` equals `lk_back` (1 = negative displacement, predicted taken).
- R5: An update with `up_taken` = 0 for an address that has no entry creates no entry.
- R6: An update with `up_taken` = 1 for an address that has no entry creates one holding `up_target`, and the lookup one cycle later hits.
- R7: On a hit update with `up_taken` = 1, `up_pred_taken` = 1 and a target different from the stored one, the first such misfetch keeps the old target. The second consecutive misfetch replaces it with the new target.
- R8: A hit update with `up_taken` = 1 and a target equal to the stored one clears the misfetch count, so the next wrong target alone does not replace the entry.
- R9: A wrong target reported with `up_pred_taken` = 0 is not a misfetch and leaves the count and the target unchanged.
- R10: An allocation fills an invalid way of the set first (way 0 before way 1). Otherwise it evicts the least recently used way. Every hit update and every allocation marks its way most recently used, and this includes not-taken hits.
- R11: The set index is `lk_pc`[8:2] and the remaining upper bits form the tag. Two branches in one set with different tags are held side by side, and a branch in another set does not hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_pc | input | 32 | Fetch address being looked up |
| lk_dir_taken | input | 1 | Direction predictor's taken bit for this fetch |
| lk_back | input | 1 | Displacement sign of the branch (1 = backward) |
| lk_hit | output | 1 | Lookup found a valid entry with matching tag |
| lk_taken | output | 1 | Direction used for this fetch |
| lk_next_pc | output | 32 | Address to fetch next |
| up_valid | input | 1 | Update port carries a resolved branch this cycle |
| up_pc | input | 32 | Address of the resolved branch |
| up_taken | input | 1 | Resolved direction |
| up_pred_taken | input | 1 | Branch had hit and been predicted taken at fetch |
| up_target | input | 32 | Resolved target address |

## Verification
The lookup outputs are combinational from the stored array, so each lookup result is due in the same cycle as its inputs. The bench samples it one nanosecond after the falling edge on which the inputs were driven. An update takes effect at the next rising edge, so the first lookup that can show it is the one driven on the falling edge after that. The driver never checks a lookup earlier than that edge. Every expected item is queued by the driver when it applies the stimulus. The monitor pops one item per sampled cycle, and that keeps each comparison fixed to the cycle that is due.

// File: rtl/tgtbuf_pkg.sv
// Shared definitions for the branch target buffer.
// Assumes a fixed associativity of two, because the replacement state is one bit per set.
package tgtbuf_pkg;
    localparam int WAYS = 2;

    // Write action that the update controller selects for one way.
    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_CLEAR,
        ACT_BUMP,
        ACT_REPLACE,
        ACT_ALLOC
    } way_act_e;
endpackage

// File: rtl/tgtbuf_way.sv
// One way of the buffer: valid bits, tags, targets and misfetch counters for every set.
// It has a lookup read port and an update read port, both combinational.
// It has one write port, driven by an action code from the controller.
// Assumes that at most one action per cycle targets this way.
module tgtbuf_way
    import tgtbuf_pkg::*;
#(
    parameter int SETS  = 128,
    parameter int IDX_W = 7,
    parameter int TAG_W = 23,
    parameter int PC_W  = 32,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    output logic             lk_vld,
    output logic [TAG_W-1:0] lk_tag,
    output logic [PC_W-1:0]  lk_tgt,
    input  logic [IDX_W-1:0] up_idx,
    output logic             up_vld,
    output logic [TAG_W-1:0] up_tag,
    output logic [PC_W-1:0]  up_tgt,
    output logic [CNT_W-1:0] up_cnt,
    input  way_act_e         act,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PC_W-1:0]  wr_tgt
);
    logic             vld_q [SETS];
    logic [TAG_W-1:0] tag_q [SETS];
    logic [PC_W-1:0]  tgt_q [SETS];
    logic [CNT_W-1:0] cnt_q [SETS];

    // Valid bits: cleared by reset, set by an allocation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= 1'b0;
            end
        end else if (act == ACT_ALLOC) begin
            vld_q[up_idx] <= 1'b1;
        end
    end

    // Payload: tag, target and misfetch counter, changed only by the update actions.
    always_ff @(posedge clk) begin
        case (act)
            ACT_ALLOC: begin
                tag_q[up_idx] <= wr_tag;
                tgt_q[up_idx] <= wr_tgt;
                cnt_q[up_idx] <= '0;
            end
            ACT_REPLACE: begin
                tgt_q[up_idx] <= wr_tgt;
                cnt_q[up_idx] <= '0;
            end
            ACT_BUMP:  cnt_q[up_idx] <= cnt_q[up_idx] + 1'b1;
            ACT_CLEAR: cnt_q[up_idx] <= '0;
            default: ;
        endcase
    end

    // Lookup read port.
    always_comb begin
        lk_vld = vld_q[lk_idx];
        lk_tag = tag_q[lk_idx];
        lk_tgt = tgt_q[lk_idx];
    end

    // Update read port.
    always_comb begin
        up_vld = vld_q[up_idx];
        up_tag = tag_q[up_idx];
        up_tgt = tgt_q[up_idx];
        up_cnt = cnt_q[up_idx];
    end
endmodule

// File: rtl/tgtbuf_lru.sv
// Replacement state: one bit per set that names the way to evict next.
// Assumes two ways. Touching a way points the bit at the other one.
module tgtbuf_lru #(
    parameter int SETS  = 128,
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             touch,
    input  logic             touch_way,
    output logic             victim
);
    logic [SETS-1:0] lru_q;

    // Record the most recent use of a way in the addressed set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lru_q <= '0;
        end else if (touch) begin
            lru_q[idx] <= ~touch_way;
        end
    end

    // Current victim for the addressed set.
    always_comb victim = lru_q[idx];
endmodule

// File: rtl/tgtbuf_ctrl.sv
// Update controller. It matches a resolved branch against both ways of its set.
// On a match it applies the misfetch hysteresis. On a taken miss it picks a way
// to allocate. It reports which way becomes most recently used.
// Assumes a tag is present in at most one way of a set, which holds because
// allocation happens only on a miss.
module tgtbuf_ctrl
    import tgtbuf_pkg::*;
#(
    parameter int TAG_W      = 23,
    parameter int PC_W       = 32,
    parameter int CNT_W      = 2,
    parameter int MISS_LIMIT = 2
) (
    input  logic                       up_valid,
    input  logic                       up_taken,
    input  logic                       up_pred_taken,
    input  logic [TAG_W-1:0]           up_tag,
    input  logic [PC_W-1:0]            up_target,
    input  logic [WAYS-1:0]            way_vld,
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [WAYS-1:0][PC_W-1:0]  way_tgt,
    input  logic [WAYS-1:0][CNT_W-1:0] way_cnt,
    input  logic                       victim,
    output way_act_e [WAYS-1:0]        act,
    output logic                       touch,
    output logic                       touch_way
);
    logic [WAYS-1:0] match;
    logic            any_match;
    logic            hit_way;
    logic            alloc_way;
    way_act_e        hit_act;

    // Tag comparison per way.
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            match[w] = up_valid && way_vld[w] && (way_tag[w] == up_tag);
        end
        any_match = |match;
        hit_way   = match[1];
    end

    // Hysteresis decision for the matched entry.
    always_comb begin
        hit_act = ACT_IDLE;
        if (up_taken) begin
            if (way_tgt[hit_way] == up_target) begin
                hit_act = ACT_CLEAR;
            end else if (up_pred_taken) begin
                if (32'(way_cnt[hit_way]) + 1 >= MISS_LIMIT) begin
                    hit_act = ACT_REPLACE;
                end else begin
                    hit_act = ACT_BUMP;
                end
            end
        end
    end

    // Allocation way: an invalid way first, otherwise the replacement victim.
    always_comb begin
        if (!way_vld[0]) begin
            alloc_way = 1'b0;
        end else if (!way_vld[1]) begin
            alloc_way = 1'b1;
        end else begin
            alloc_way = victim;
        end
    end

    // Per-way action and replacement touch.
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            act[w] = ACT_IDLE;
        end
        touch     = 1'b0;
        touch_way = 1'b0;
        if (any_match) begin
            act[hit_way] = hit_act;
            touch        = 1'b1;
            touch_way    = hit_way;
        end else if (up_valid && up_taken) begin
            act[alloc_way] = ACT_ALLOC;
            touch          = 1'b1;
            touch_way      = alloc_way;
        end
    end
endmodule

// File: rtl/tgtbuf_sel.sv
// Lookup selector. It compares the fetch tag against both ways and forms the
// direction and next fetch address. On a miss it uses the static displacement rule.
// Assumes the way contents are stable during the cycle (read from registers).
module tgtbuf_sel
    import tgtbuf_pkg::*;
#(
    parameter int TAG_W = 23,
    parameter int PC_W  = 32,
    parameter int OFS_W = 2
) (
    input  logic [PC_W-1:0]            lk_pc,
    input  logic [TAG_W-1:0]           lk_tag,
    input  logic                       lk_dir_taken,
    input  logic                       lk_back,
    input  logic [WAYS-1:0]            way_vld,
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [WAYS-1:0][PC_W-1:0]  way_tgt,
    output logic                       hit,
    output logic                       taken,
    output logic [PC_W-1:0]            next_pc
);
    localparam logic [PC_W-1:0] STEP = PC_W'(1) << OFS_W;

    logic [WAYS-1:0] match;
    logic [PC_W-1:0] hit_tgt;

    // Tag comparison and target mux.
    always_comb begin
        hit_tgt = '0;
        for (int w = 0; w < WAYS; w++) begin
            match[w] = way_vld[w] && (way_tag[w] == lk_tag);
            if (match[w]) begin
                hit_tgt = way_tgt[w];
            end
        end
        hit = |match;
    end

    // Direction and next fetch address.
    always_comb begin
        if (hit) begin
            taken   = lk_dir_taken;
            next_pc = lk_dir_taken ? hit_tgt : lk_pc + STEP;
        end else begin
            taken   = lk_back;
            next_pc = lk_pc + STEP;
        end
    end
endmodule

// File: rtl/tgt_buffer.sv
// Top of the branch target buffer. It splits both addresses into index and tag,
// builds two ways with a generate loop, and connects the lookup selector,
// the update controller and the replacement state.
// Assumes the PCs are aligned to 2**OFS_W bytes and a single update per cycle.
// A lookup sees the contents as they stood before a same-cycle update.
module tgt_buffer
    import tgtbuf_pkg::*;
#(
    parameter int PC_W       = 32,
    parameter int ENTRIES    = 256,
    parameter int OFS_W      = 2,
    parameter int MISS_LIMIT = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    input  logic            lk_dir_taken,
    input  logic            lk_back,
    output logic            lk_hit,
    output logic            lk_taken,
    output logic [PC_W-1:0] lk_next_pc,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken,
    input  logic            up_pred_taken,
    input  logic [PC_W-1:0] up_target
);
    localparam int SETS  = ENTRIES / WAYS;
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = PC_W - IDX_W - OFS_W;
    localparam int CNT_W = $clog2(MISS_LIMIT + 1);

    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;

    logic [WAYS-1:0]            lk_vld_w, up_vld_w;
    logic [WAYS-1:0][TAG_W-1:0] lk_tag_w, up_tag_w;
    logic [WAYS-1:0][PC_W-1:0]  lk_tgt_w, up_tgt_w;
    logic [WAYS-1:0][CNT_W-1:0] up_cnt_w;
    way_act_e [WAYS-1:0]        act_w;

    logic victim, touch, touch_way;

    // Address split into set index and tag.
    always_comb begin
        lk_idx = lk_pc[OFS_W +: IDX_W];
        lk_tag = lk_pc[PC_W-1 -: TAG_W];
        up_idx = up_pc[OFS_W +: IDX_W];
        up_tag = up_pc[PC_W-1 -: TAG_W];
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        tgtbuf_way #(
            .SETS (SETS),
            .IDX_W(IDX_W),
            .TAG_W(TAG_W),
            .PC_W (PC_W),
            .CNT_W(CNT_W)
        ) u_way (
            .clk   (clk),
            .rst_n (rst_n),
            .lk_idx(lk_idx),
            .lk_vld(lk_vld_w[w]),
            .lk_tag(lk_tag_w[w]),
            .lk_tgt(lk_tgt_w[w]),
            .up_idx(up_idx),
            .up_vld(up_vld_w[w]),
            .up_tag(up_tag_w[w]),
            .up_tgt(up_tgt_w[w]),
            .up_cnt(up_cnt_w[w]),
            .act   (act_w[w]),
            .wr_tag(up_tag),
            .wr_tgt(up_target)
        );
    end

    tgtbuf_lru #(
        .SETS (SETS),
        .IDX_W(IDX_W)
    ) u_lru (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (up_idx),
        .touch    (touch),
        .touch_way(touch_way),
        .victim   (victim)
    );

    tgtbuf_ctrl #(
        .TAG_W     (TAG_W),
        .PC_W      (PC_W),
        .CNT_W     (CNT_W),
        .MISS_LIMIT(MISS_LIMIT)
    ) u_ctrl (
        .up_valid     (up_valid),
        .up_taken     (up_taken),
        .up_pred_taken(up_pred_taken),
        .up_tag       (up_tag),
        .up_target    (up_target),
        .way_vld      (up_vld_w),
        .way_tag      (up_tag_w),
        .way_tgt      (up_tgt_w),
        .way_cnt      (up_cnt_w),
        .victim       (victim),
        .act          (act_w),
        .touch        (touch),
        .touch_way    (touch_way)
    );

    tgtbuf_sel #(
        .TAG_W(TAG_W),
        .PC_W (PC_W),
        .OFS_W(OFS_W)
    ) u_sel (
        .lk_pc       (lk_pc),
        .lk_tag      (lk_tag),
        .lk_dir_taken(lk_dir_taken),
        .lk_back     (lk_back),
        .way_vld     (lk_vld_w),
        .way_tag     (lk_tag_w),
        .way_tgt     (lk_tgt_w),
        .hit         (lk_hit),
        .taken       (lk_taken),
        .next_pc     (lk_next_pc)
    );
endmodule

// File: rtl/tgtbuf_chk.sv
// Port-level properties of the branch target buffer, bound to every instance of the top.
module tgtbuf_chk #(
    parameter int PC_W  = 32,
    parameter int OFS_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] lk_pc,
    input logic            lk_dir_taken,
    input logic            lk_back,
    input logic            lk_hit,
    input logic            lk_taken,
    input logic [PC_W-1:0] lk_next_pc,
    input logic            up_valid,
    input logic [PC_W-1:0] up_pc,
    input logic            up_taken
);
    localparam logic [PC_W-1:0] STEP = PC_W'(1) << OFS_W;

    // R1
    empty_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !lk_hit);

    // R4
    miss_static_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> lk_taken == lk_back);

    // R4
    miss_sequential_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> lk_next_pc == lk_pc + STEP);

    // R2
    hit_follows_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_taken == lk_dir_taken);

    // R3
    hit_nt_sequential_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && !lk_dir_taken) |-> lk_next_pc == lk_pc + STEP);

    // R5
    no_alloc_nt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_taken && !lk_hit && lk_pc == up_pc)
        |=> (lk_pc != $past(lk_pc)) || !lk_hit);

    // R6
    alloc_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_taken) |=> (lk_pc != $past(up_pc)) || lk_hit);
endmodule

bind tgt_buffer tgtbuf_chk #(
    .PC_W (PC_W),
    .OFS_W(OFS_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_pc       (lk_pc),
    .lk_dir_taken(lk_dir_taken),
    .lk_back     (lk_back),
    .lk_hit      (lk_hit),
    .lk_taken    (lk_taken),
    .lk_next_pc  (lk_next_pc),
    .up_valid    (up_valid),
    .up_pc       (up_pc),
    .up_taken    (up_taken)
);

// File: tb/tgt_buffer_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues the expected lookup result, and the monitor compares one per cycle.
module tgt_buffer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        lk_dir_taken = 1'b0;
    logic        lk_back = 1'b0;
    logic        lk_hit, lk_taken;
    logic [31:0] lk_next_pc;
    logic        up_valid = 1'b0;
    logic [31:0] up_pc = '0;
    logic        up_taken = 1'b0;
    logic        up_pred_taken = 1'b0;
    logic [31:0] up_target = '0;

    typedef struct {
        logic        hit;
        logic        taken;
        logic [31:0] nxt;
        string       req;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    localparam logic [31:0] A = 32'h0000_1000;
    localparam logic [31:0] B = 32'h0000_1200;
    localparam logic [31:0] C = 32'h0000_1400;
    localparam logic [31:0] D = 32'h0000_1004;

    always #2.5 clk = ~clk;

    tgt_buffer u_tgt_buffer (
        .clk          (clk),
        .rst_n        (rst_n),
        .lk_pc        (lk_pc),
        .lk_dir_taken (lk_dir_taken),
        .lk_back      (lk_back),
        .lk_hit       (lk_hit),
        .lk_taken     (lk_taken),
        .lk_next_pc   (lk_next_pc),
        .up_valid     (up_valid),
        .up_pc        (up_pc),
        .up_taken     (up_taken),
        .up_pred_taken(up_pred_taken),
        .up_target    (up_target)
    );

    task automatic look(input logic [31:0] pc, input logic dir, input logic back,
                        input logic e_hit, input logic e_taken, input logic [31:0] e_nxt,
                        input string req);
        exp_t e;
        @(negedge clk);
        up_valid     = 1'b0;
        lk_pc        = pc;
        lk_dir_taken = dir;
        lk_back      = back;
        e.hit = e_hit; e.taken = e_taken; e.nxt = e_nxt; e.req = req;
        q.push_back(e);
    endtask

    task automatic upd(input logic [31:0] pc, input logic tk, input logic pred,
                       input logic [31:0] tgt);
        @(negedge clk);
        up_valid      = 1'b1;
        up_pc         = pc;
        up_taken      = tk;
        up_pred_taken = pred;
        up_target     = tgt;
    endtask

    // Monitor: compare one queued expectation per cycle, 1 ns after the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (lk_hit !== e.hit || lk_taken !== e.taken || lk_next_pc !== e.nxt) begin
                    n_fail++;
                    $display("FAIL %s: hit/taken/next = %0b/%0b/%h, expected %0b/%0b/%h",
                             e.req, lk_hit, lk_taken, lk_next_pc, e.hit, e.taken, e.nxt);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state, R4 static fallback
        look(A, 1'b1, 1'b0, 1'b0, 1'b0, A + 4, "R1 empty after reset");
        look(A, 1'b0, 1'b1, 1'b0, 1'b1, A + 4, "R4 backward miss");
        look(A, 1'b1, 1'b0, 1'b0, 1'b0, A + 4, "R4 forward miss ignores dir");
        // R5 not-taken resolution allocates nothing
        upd(A, 1'b0, 1'b0, 32'h2000);
        look(A, 1'b1, 1'b0, 1'b0, 1'b0, A + 4, "R5 no entry for not-taken");
        // R6 allocation, R2 and R3 hit behaviour
        upd(A, 1'b1, 1'b0, 32'h2000);
        look(A, 1'b1, 1'b0, 1'b1, 1'b1, 32'h2000, "R6 R2 hit taken");
        look(A, 1'b0, 1'b1, 1'b1, 1'b0, A + 4, "R3 hit not taken");
        // R7 two misfetches replace the target
        upd(A, 1'b1, 1'b1, 32'h3000);
        look(A, 1'b1, 1'b0, 1'b1, 1'b1, 32'h2000, "R7 first misfetch keeps target");
        upd(A, 1'b1, 1'b1, 32'h3000);
        look(A, 1'b1, 1'b0, 1'b1, 1'b1, 32'h3000, "R7 second misfetch replaces");
        // R8 a correct target clears the count
        upd(A, 1'b1, 1'b1, 32'h4000);
        upd(A, 1'b1, 1'b1, 32'h3000);
        upd(A, 1'b1, 1'b1, 32'h4000);
        look(A, 1'b1, 1'b0, 1'b1, 1'b1, 32'h3000, "R8 count cleared by correct target");
        upd(A, 1'b1, 1'b1, 32'h4000);
        look(A, 1'b1, 1'b0, 1'b1, 1'b1, 32'h4000, "R8 consecutive pair replaces");
        // R9 wrong target without a taken prediction is not counted
        upd(A, 1'b1, 1'b0, 32'h5000);
        upd(A, 1'b1, 1'b0, 32'h5000);
        upd(A, 1'b1, 1'b1, 32'h5000);
        look(A, 1'b1, 1'b0, 1'b1, 1'b1, 32'h4000, "R9 unpredicted wrong target ignored");
        // R11 two tags in one set, other set unaffected
        upd(B, 1'b1, 1'b0, 32'h6000);
        look(B, 1'b1, 1'b0, 1'b1, 1'b1, 32'h6000, "R11 second way holds B");
        look(A, 1'b1, 1'b0, 1'b1, 1'b1, 32'h4000, "R11 A kept beside B");
        look(D, 1'b1, 1'b0, 1'b0, 1'b0, D + 4, "R11 other set misses");
        // R10 LRU victim selection, touched by a taken hit
        upd(A, 1'b1, 1'b1, 32'h4000);
        upd(C, 1'b1, 1'b0, 32'h7000);
        look(B, 1'b1, 1'b0, 1'b0, 1'b0, B + 4, "R10 LRU way B evicted");
        look(A, 1'b1, 1'b0, 1'b1, 1'b1, 32'h4000, "R10 recently used A kept");
        look(C, 1'b1, 1'b0, 1'b1, 1'b1, 32'h7000, "R10 C allocated");
        // R10 a not-taken hit also marks its way recently used
        upd(A, 1'b0, 1'b0, 32'h0);
        upd(B, 1'b1, 1'b0, 32'h8000);
        look(C, 1'b1, 1'b0, 1'b0, 1'b0, C + 4, "R10 C evicted after not-taken touch of A");
        look(A, 1'b1, 1'b0, 1'b1, 1'b1, 32'h4000, "R10 A protected by not-taken hit");
        look(B, 1'b1, 1'b0, 1'b1, 1'b1, 32'h8000, "R10 B reallocated");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule